// File: doc/BRIEF.md
# Serial Port Control and Status Register

This block is the 16-bit control and status register of a synchronous serial port. Its upper byte is a setup byte that software writes and reads back. Its lower byte holds eight read-only status flags. From this byte the block drives the port enable, the receive bit order and the fixed-clock divider selection as plain control outputs.

The transmit and receive datapaths send the block single-cycle strobes. One strobe marks a word event: a received word has landed in the receive holding register, or the transmit shifter has taken a word from the transmit holding register. Another strobe marks that the first bit of the following word has completed. Each word event is held as a pending status, and that status becomes visible only at the next first-bit strobe. Receive overrun and transmit underrun are sticky. They clear through a two-step sequence: a read of this register while an error is pending, then a read or write of either data register with no other access in between.

All pins here are control and status pins. There is no streaming data path, so there is no valid/ready handshake. Each bus access is a single-cycle strobe, and the block never stalls it.

Top module: `sport_csr`

## Requirements
- R1: After reset, every bit of the register reads 0 and all control outputs are 0.
- R2: A write to the register (acc_sel=0) stores bits 15..8, which read back unchanged. Bits 7..0 ignore writes, and a write never changes a status flag.
- R3: While the enable bit (bit 8) is 0, word-event and first-bit strobes are ignored and no status flag is set.
- R4: Status layout, from bit 7 down to bit 0: receive ready, transmit empty, receive overrun, transmit underrun, transmit frame sync, receive frame sync, receive full, transmit empty-level. A word event only makes status pending. The flags become visible in the cycle after the first-bit strobe of that direction. At that point the frame-sync and level flags take the input values sampled at the word event.
- R5: A read of the receive data register (acc_sel=1) clears receive ready. A write of the transmit data register (acc_sel=2) clears transmit empty. Either clear takes effect on the next cycle.
- R6: A word event while the visible ready flag of its direction is 1 raises that direction's error (overrun or underrun). The error stays set until a register read made while an error is pending is followed directly by an access to a data register (acc_sel 1 or 2). Any other access between the two steps cancels the sequence.
- R7: If an error commit and the clearing data access fall in the same cycle, the error stays set. The same rule applies to the ready flag: a commit and a ready-clearing access in the same cycle leave ready set.
- R8: Bit 15 drives div_bypass_o: 1 means the fixed clock equals the peripheral clock, 0 means it is divided by 4. Bit 14 drives rx_lsb_first_o: 0 means MSB first, 1 means LSB first. Bit 8 drives port_en_o, and setup_o carries bits 15..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Single-cycle bus access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 register, 1 receive data, 2 transmit data, 3 other |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Register contents, setup byte over status byte |
| rx_word_i | input | 1 | Received word landed in holding register |
| rx_first_i | input | 1 | First bit of next received word done |
| rx_fs_i | input | 1 | Receive frame sync seen for the word |
| rx_full_i | input | 1 | Receive buffer full level |
| tx_word_i | input | 1 | Transmit shifter took a word |
| tx_first_i | input | 1 | First bit of next sent word done |
| tx_fs_i | input | 1 | Transmit frame sync seen for the word |
| tx_empty_i | input | 1 | Transmit buffer empty level |
| div_bypass_o | output | 1 | Fixed clock divider bypass |
| rx_lsb_first_o | output | 1 | Receive bit order |
| port_en_o | output | 1 | Port enable |
| setup_o | output | 8 | Whole setup byte |

## Verification
The bench builds the block with its default 16-bit width, so the setup byte has only 256 values. All of them are swept, and each sweep step checks that the byte reads back, that the exported fields are correct and that the lower byte ignores the write. The frame-sync and level inputs are also swept through all four combinations in both directions, both before and after the commit strobe. Targeted sequences then cover overrun and underrun, the interrupted and completed clear sequences, and the same-cycle collision of a commit with a clear.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    SEL_CSR   = 2'd0,
    SEL_RXD   = 2'd1,
    SEL_TXD   = 2'd2,
    SEL_OTHER = 2'd3
  } acc_sel_e;

  localparam int ST_RDY_RX = 7;
  localparam int ST_RDY_TX = 6;
  localparam int ST_ERR_RX = 5;
  localparam int ST_ERR_TX = 4;
  localparam int ST_FS_TX  = 3;
  localparam int ST_FS_RX  = 2;
  localparam int ST_LVL_RX = 1;
  localparam int ST_LVL_TX = 0;

  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int N_DIR  = 2;
endpackage

// File: rtl/sport_setup_reg.sv
module sport_setup_reg #(
  parameter int HALF = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [HALF-1:0] wr_byte,
  output logic [HALF-1:0] setup_q,
  output logic            div_bypass,
  output logic            lsb_first,
  output logic            port_en
);
  localparam int DIVB_BIT = HALF - 1;
  localparam int LSBF_BIT = HALF - 2;
  localparam int EN_BIT   = 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) setup_q <= '0;
    else if (wr_en) setup_q <= wr_byte;
  end

  assign div_bypass = setup_q[DIVB_BIT];
  assign lsb_first  = setup_q[LSBF_BIT];
  assign port_en    = setup_q[EN_BIT];

  // R2: setup byte changes only on a register write
  a_r2_setup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(setup_q));
endmodule

// File: rtl/sport_dir_flags.sv
module sport_dir_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic word_evt,
  input  logic commit,
  input  logic fs_i,
  input  logic lvl_i,
  input  logic data_acc,
  input  logic err_clr,
  output logic ready_o,
  output logic err_o,
  output logic fs_o,
  output logic lvl_o
);
  logic pend_rdy, pend_err, pend_fs, pend_lvl;
  logic pr_n, pe_n, pf_n, pl_n;
  logic rdy_n, err_n, fs_n, lvl_n;
  logic evt, cmt, rdy_eff;

  assign evt = en && word_evt;
  assign cmt = en && commit;
  assign rdy_eff = ready_o || (cmt && pend_rdy);

  always_comb begin
    pr_n = pend_rdy;
    pe_n = pend_err;
    pf_n = pend_fs;
    pl_n = pend_lvl;
    if (cmt) begin
      pr_n = 1'b0;
      pe_n = 1'b0;
    end
    if (evt) begin
      pr_n = 1'b1;
      pf_n = fs_i;
      pl_n = lvl_i;
      if (rdy_eff) pe_n = 1'b1;
    end
  end

  always_comb begin
    rdy_n = ready_o;
    err_n = err_o;
    fs_n  = fs_o;
    lvl_n = lvl_o;
    if (data_acc) rdy_n = 1'b0;
    if (err_clr)  err_n = 1'b0;
    if (cmt) begin
      if (pend_rdy) rdy_n = 1'b1;
      if (pend_err) err_n = 1'b1;
      fs_n  = pend_fs;
      lvl_n = pend_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rdy <= 1'b0;
      pend_err <= 1'b0;
      pend_fs  <= 1'b0;
      pend_lvl <= 1'b0;
      ready_o  <= 1'b0;
      err_o    <= 1'b0;
      fs_o     <= 1'b0;
      lvl_o    <= 1'b0;
    end else begin
      pend_rdy <= pr_n;
      pend_err <= pe_n;
      pend_fs  <= pf_n;
      pend_lvl <= pl_n;
      ready_o  <= rdy_n;
      err_o    <= err_n;
      fs_o     <= fs_n;
      lvl_o    <= lvl_n;
    end
  end

  // R4: visible ready only rises right after an enabled commit strobe
  a_r4_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(en && commit));
  // R5: a clearing access without a commit drops ready
  a_r5_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !commit |=> !ready_o);
  // R6: error is sticky unless cleared
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !err_clr |=> err_o);
  // R7: commit of a pending error beats a same-cycle clear
  a_r7_err_priority: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && cmt && pend_err |=> err_o);
endmodule

// File: rtl/sport_err_clear.sv
module sport_err_clear (
  input  logic clk,
  input  logic rst_n,
  input  logic any_acc,
  input  logic csr_rd,
  input  logic data_acc,
  input  logic err_pend,
  output logic armed_o,
  output logic clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_o <= 1'b0;
    else if (any_acc) armed_o <= csr_rd && err_pend;
  end

  assign clr_o = data_acc && armed_o;

  // R6: arming needs an error pending at the register read
  a_r6_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(csr_rd && err_pend));
  // R6: a data access always consumes the armed state
  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> !armed_o);
endmodule

// File: rtl/sport_csr.sv
module sport_csr #(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [1:0]         acc_sel,
  input  logic [REG_W-1:0]   acc_wdata,
  output logic [REG_W-1:0]   acc_rdata,
  input  logic               rx_word_i,
  input  logic               rx_first_i,
  input  logic               rx_fs_i,
  input  logic               rx_full_i,
  input  logic               tx_word_i,
  input  logic               tx_first_i,
  input  logic               tx_fs_i,
  input  logic               tx_empty_i,
  output logic               div_bypass_o,
  output logic               rx_lsb_first_o,
  output logic               port_en_o,
  output logic [REG_W/2-1:0] setup_o
);
  import sport_pkg::*;

  localparam int HALF = REG_W / 2;

  logic csr_wr, csr_rd, rxd_rd, txd_wr, data_acc, err_clr, armed, err_pend;
  logic lo_unused;
  logic [N_DIR-1:0] d_word, d_first, d_fs_in, d_lvl_in, d_acc;
  logic [N_DIR-1:0] d_rdy, d_err, d_fs, d_lvl;
  logic [HALF-1:0] status;

  assign csr_wr   = acc_en &&  acc_wr && (acc_sel == SEL_CSR);
  assign csr_rd   = acc_en && !acc_wr && (acc_sel == SEL_CSR);
  assign rxd_rd   = acc_en && !acc_wr && (acc_sel == SEL_RXD);
  assign txd_wr   = acc_en &&  acc_wr && (acc_sel == SEL_TXD);
  assign data_acc = acc_en && ((acc_sel == SEL_RXD) || (acc_sel == SEL_TXD));
  assign lo_unused = ^acc_wdata[HALF-1:0];

  sport_setup_reg #(.HALF(HALF)) u_setup (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .wr_byte(acc_wdata[REG_W-1:HALF]),
    .setup_q(setup_o), .div_bypass(div_bypass_o), .lsb_first(rx_lsb_first_o),
    .port_en(port_en_o)
  );

  assign d_word   = {tx_word_i,  rx_word_i};
  assign d_first  = {tx_first_i, rx_first_i};
  assign d_fs_in  = {tx_fs_i,    rx_fs_i};
  assign d_lvl_in = {tx_empty_i, rx_full_i};
  assign d_acc    = {txd_wr,     rxd_rd};

  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    sport_dir_flags u_flags (
      .clk(clk), .rst_n(rst_n), .en(port_en_o),
      .word_evt(d_word[g]), .commit(d_first[g]),
      .fs_i(d_fs_in[g]), .lvl_i(d_lvl_in[g]),
      .data_acc(d_acc[g]), .err_clr(err_clr),
      .ready_o(d_rdy[g]), .err_o(d_err[g]), .fs_o(d_fs[g]), .lvl_o(d_lvl[g])
    );
  end

  assign err_pend = |d_err;

  sport_err_clear u_clr (
    .clk(clk), .rst_n(rst_n), .any_acc(acc_en), .csr_rd(csr_rd),
    .data_acc(data_acc), .err_pend(err_pend), .armed_o(armed), .clr_o(err_clr)
  );

  always_comb begin
    status = '0;
    status[ST_RDY_RX] = d_rdy[DIR_RX];
    status[ST_RDY_TX] = d_rdy[DIR_TX];
    status[ST_ERR_RX] = d_err[DIR_RX];
    status[ST_ERR_TX] = d_err[DIR_TX];
    status[ST_FS_TX]  = d_fs[DIR_TX];
    status[ST_FS_RX]  = d_fs[DIR_RX];
    status[ST_LVL_RX] = d_lvl[DIR_RX];
    status[ST_LVL_TX] = d_lvl[DIR_TX];
  end

  assign acc_rdata = {setup_o, status};

  // R3: disabled port without data accesses keeps status frozen
  a_r3_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_o && !data_acc |=> $stable(status));
  // R6: an error only falls when the sequence was armed
  a_r6_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_pend) |-> $past(armed));
  // R2: a register write alone does not touch status
  a_r2_write_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && !rx_first_i && !tx_first_i |=> $stable(status));
endmodule

// File: tb/sport_csr_tb.sv
module sport_csr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 0, acc_wr = 0;
  logic [1:0] acc_sel = 0;
  logic [15:0] acc_wdata = 0;
  logic [15:0] acc_rdata;
  logic rx_word_i = 0, rx_first_i = 0, rx_fs_i = 0, rx_full_i = 0;
  logic tx_word_i = 0, tx_first_i = 0, tx_fs_i = 0, tx_empty_i = 0;
  logic div_bypass_o, rx_lsb_first_o, port_en_o;
  logic [7:0] setup_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sport_csr u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle;
    @(negedge clk);
  endtask

  task automatic acc(input logic wr, input logic [1:0] sel, input logic [15:0] d);
    acc_en = 1; acc_wr = wr; acc_sel = sel; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic ev(input logic rw, input logic rf, input logic tw, input logic tf);
    rx_word_i = rw; rx_first_i = rf; tx_word_i = tw; tx_first_i = tf;
    @(negedge clk);
    rx_word_i = 0; rx_first_i = 0; tx_word_i = 0; tx_first_i = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset reg", acc_rdata, 16'h0000);
    chk("R1 reset outs", {13'd0, div_bypass_o, rx_lsb_first_o, port_en_o}, 16'h0);
    rst_n = 1;
    idle();

    // R2 / R8 exhaustive setup sweep
    for (int v = 0; v < 256; v++) begin
      acc(1, 2'd0, {v[7:0], ~v[7:0]});
      chk("R2 readback", acc_rdata, {v[7:0], 8'h00});
      chk("R8 exports", {setup_o, 5'd0, div_bypass_o, rx_lsb_first_o, port_en_o},
          {v[7:0], 5'd0, v[7], v[6], v[0]});
    end

    // R3 disabled
    acc(1, 2'd0, 16'h0000);
    rx_fs_i = 1; rx_full_i = 1; tx_fs_i = 1; tx_empty_i = 1;
    ev(1, 0, 1, 0);
    ev(0, 1, 0, 1);
    ev(1, 1, 1, 1);
    idle();
    chk("R3 disabled status", {8'd0, acc_rdata[7:0]}, 16'h0000);

    acc(1, 2'd0, 16'h0100);
    rx_fs_i = 0; rx_full_i = 0; tx_fs_i = 0; tx_empty_i = 0;

    // R4 / R5 receive sweep
    for (int c = 0; c < 4; c++) begin
      rx_fs_i = c[1]; rx_full_i = c[0];
      ev(1, 0, 0, 0);
      chk("R4 rx not before first bit", {15'd0, acc_rdata[7]}, 16'd0);
      ev(0, 1, 0, 0);
      chk("R4 rx commit", {8'd0, acc_rdata[7:0]}, {8'd0, 8'h80 | (8'(c[1]) << 2) | (8'(c[0]) << 1)});
      acc(0, 2'd1, 16'h0);
      chk("R5 rx read clears ready", {8'd0, acc_rdata[7:0]}, {8'd0, (8'(c[1]) << 2) | (8'(c[0]) << 1)});
    end
    // R4 / R5 transmit sweep
    for (int c = 0; c < 4; c++) begin
      tx_fs_i = c[1]; tx_empty_i = c[0];
      ev(0, 0, 1, 0);
      chk("R4 tx not before first bit", {15'd0, acc_rdata[6]}, 16'd0);
      ev(0, 0, 0, 1);
      chk("R4 tx commit", {8'd0, acc_rdata[7:0]}, {8'd0, 8'h46 | (8'(c[1]) << 3) | 8'(c[0])});
      acc(1, 2'd2, 16'h0);
      chk("R5 tx write clears empty", {15'd0, acc_rdata[6]}, 16'd0);
    end
    rx_fs_i = 0; rx_full_i = 0; tx_fs_i = 0; tx_empty_i = 0;

    // R6 overrun and clear sequence
    ev(1, 0, 0, 0);
    ev(0, 1, 0, 0);
    ev(1, 0, 0, 0);
    chk("R4 overrun pending only", {15'd0, acc_rdata[5]}, 16'd0);
    ev(0, 1, 0, 0);
    chk("R6 overrun set", {8'd0, acc_rdata[7:0]}, 16'h00A9);
    acc(0, 2'd1, 16'h0);
    chk("R6 no clear without reg read", {15'd0, acc_rdata[5]}, 16'd1);
    acc(0, 2'd0, 16'h0);
    acc(0, 2'd3, 16'h0);
    acc(0, 2'd1, 16'h0);
    chk("R6 interrupted sequence", {15'd0, acc_rdata[5]}, 16'd1);
    acc(0, 2'd0, 16'h0);
    acc(0, 2'd1, 16'h0);
    chk("R6 overrun cleared", {15'd0, acc_rdata[5]}, 16'd0);

    // R6 underrun
    ev(0, 0, 1, 0);
    ev(0, 0, 0, 1);
    ev(0, 0, 1, 0);
    ev(0, 0, 0, 1);
    chk("R6 underrun set", {14'd0, acc_rdata[6], acc_rdata[4]}, 16'd3);
    acc(0, 2'd0, 16'h0);
    acc(1, 2'd2, 16'h0);
    chk("R6 underrun cleared", {14'd0, acc_rdata[6], acc_rdata[4]}, 16'd0);

    // R7 same-cycle priority
    ev(1, 0, 0, 0);
    ev(0, 1, 0, 0);
    ev(1, 0, 0, 0);
    ev(0, 1, 0, 0);
    ev(1, 0, 0, 0);
    acc(0, 2'd0, 16'h0);
    acc_en = 1; acc_wr = 0; acc_sel = 2'd1; rx_first_i = 1;
    @(negedge clk);
    acc_en = 0; rx_first_i = 0;
    chk("R7 commit beats clear", {14'd0, acc_rdata[7], acc_rdata[5]}, 16'd3);
    acc(0, 2'd0, 16'h0);
    acc(1, 2'd2, 16'h0);
    chk("R6 clear via tx data", {15'd0, acc_rdata[5]}, 16'd0);

    // R1 reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid-run reset", acc_rdata, 16'h0000);
    rst_n = 1;
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule